// File: doc/BRIEF.md
# Low Page Trap and Boot ROM Overlay Filter

This block sits in the path of processor data reads and flags or rewrites responses on the way back. It has two independent functions. The first raises a trap flag for any data access, read or write, whose physical address falls in the lowest page of the address space (4 KB by default). Software uses it to catch dereferences of null and near-null pointers. The second is a boot ROM overlay. When it is enabled, every data read that lands in a parameterised ROM window returns one programmable 32-bit word in place of the ROM contents.

Instruction fetches pass through untouched: they are never trapped and never overlaid. Each bus request carries the address, an instruction/data flag, a write flag and the memory read data. One cycle later a registered response comes back with the final read data and the trap flag. A small register port holds the trap control word, the overlay enable and the overlay word. The port is written synchronously and read combinationally.

Top module: `low_page_guard`

## Requirements
- R1: After reset the trap control register reads 0x00010000, the overlay enable register reads 0, the overlay word reads 0, and resp_valid and resp_trap are low.
- R2: Register select codes are 0 = trap control, 1 = overlay enable, 2 = overlay word, 3 = unused. Trap control stores only bit 0 (trap enable) and bit 16 (spare bit), and all its other bits read 0. Overlay enable stores only bit 0. The overlay word stores all 32 bits. Select 3 reads 0, and a write to it changes no register. A write takes effect on the clock edge, and reads reflect the current state.
- R3: For every cycle with bus_req high, resp_valid is high in the following cycle.
- R4: A data access (bus_fetch = 0, read or write) whose address is below PAGE_BYTES raises resp_trap together with its response, when trap enable is 1.
- R5: resp_trap stays low for instruction fetches, for addresses at or above PAGE_BYTES, and whenever trap enable is 0.
- R6: The spare bit 16 of trap control has no effect on trapping or on the returned data.
- R7: With overlay enable at 1, a data read (bus_fetch = 0, bus_write = 0) at an address in [ROM_BASE, ROM_BASE+ROM_SIZE) returns the overlay word in resp_data.
- R8: In every other case, resp_data equals the mem_rdata presented with the request. This covers fetches, writes, addresses outside the window, and overlay disabled.
- R9: Trap and overlay are evaluated independently. A data read that is both in the low page and in the ROM window returns the overlay word with resp_trap high.
- R10: In a cycle that follows a cycle without bus_req, both resp_valid and resp_trap are low, so the trap is a single-cycle pulse per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_sel |
| bus_req | input | 1 | Access valid this cycle |
| bus_addr | input | ADDR_W | Physical address |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = data write |
| mem_rdata | input | 32 | Read data from memory for this access |
| resp_valid | output | 1 | Response valid, one cycle after request |
| resp_data | output | 32 | Returned data, possibly overlaid |
| resp_trap | output | 1 | Low page trap pulse |

## Verification
The bench builds the block with a 16-bit address space, a 4 KB page and a ROM window at 0x2000 of 4 KB. It sweeps the whole address space in 128-byte steps plus each window edge, for all eight combinations of trap enable, spare bit and overlay enable and all four fetch/write kinds. A second instance has its ROM window at 0 with 2 KB, so the window overlaps the low page and both actions can be seen on one access. Because the address space is small, every decode edge and every control combination is covered directly.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_TRAP_CTL = 2'd0,
    SEL_OVL_CTL  = 2'd1,
    SEL_OVL_VAL  = 2'd2,
    SEL_NONE     = 2'd3
  } reg_sel_e;

  localparam int TRAP_EN_BIT  = 0;
  localparam int TRAP_AUX_BIT = 16;
  localparam int OVL_EN_BIT   = 0;

  localparam logic [WORD_W-1:0] TRAP_CTL_RST  = 32'h0001_0000;
  localparam logic [WORD_W-1:0] TRAP_CTL_MASK =
    (WORD_W'(1) << TRAP_EN_BIT) | (WORD_W'(1) << TRAP_AUX_BIT);
endpackage

// File: rtl/lpt_cfg_regs.sv
module lpt_cfg_regs
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              trap_en,
  output logic              ovl_en,
  output logic [WORD_W-1:0] ovl_val
);
  reg_sel_e          sel_e;
  logic              trap_en_q, trap_aux_q, ovl_en_q;
  logic [WORD_W-1:0] ovl_val_q;
  logic              wr_trap_w, wr_octl_w, wr_oval_w;

  assign sel_e     = reg_sel_e'(sel);
  assign wr_trap_w = wr_en && (sel_e == SEL_TRAP_CTL);
  assign wr_octl_w = wr_en && (sel_e == SEL_OVL_CTL);
  assign wr_oval_w = wr_en && (sel_e == SEL_OVL_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_en_q  <= TRAP_CTL_RST[TRAP_EN_BIT];
      trap_aux_q <= TRAP_CTL_RST[TRAP_AUX_BIT];
      ovl_en_q   <= 1'b0;
      ovl_val_q  <= '0;
    end else begin
      if (wr_trap_w) begin
        trap_en_q  <= wdata[TRAP_EN_BIT];
        trap_aux_q <= wdata[TRAP_AUX_BIT];
      end
      if (wr_octl_w) ovl_en_q <= wdata[OVL_EN_BIT];
      if (wr_oval_w) ovl_val_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel_e)
      SEL_TRAP_CTL: begin
        rdata[TRAP_EN_BIT]  = trap_en_q;
        rdata[TRAP_AUX_BIT] = trap_aux_q;
      end
      SEL_OVL_CTL:  rdata[OVL_EN_BIT] = ovl_en_q;
      SEL_OVL_VAL:  rdata = ovl_val_q;
      default:      rdata = '0;
    endcase
  end

  assign trap_en = trap_en_q;
  assign ovl_en  = ovl_en_q;
  assign ovl_val = ovl_val_q;

  // R2: trap control keeps its value when it is not addressed by a write
  p_trap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_trap_w |=> $stable(trap_en_q) && $stable(trap_aux_q));
  // R2: overlay word loads the written value
  p_oval_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oval_w |=> ovl_val == $past(wdata));
  // R2: unused trap control bits read as zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_e == SEL_TRAP_CTL) |-> ((rdata & ~TRAP_CTL_MASK) == '0));
  // R2: overlay enable holds without a write to it
  p_octl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_octl_w |=> $stable(ovl_en));
endmodule

// File: rtl/lpt_addr_decode.sv
module lpt_addr_decode #(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       PAGE_BYTES = 4096,
  parameter logic [ADDR_W-1:0] ROM_BASE   = 32'h0001_0000,
  parameter logic [ADDR_W:0]   ROM_SIZE   = 33'h0_0001_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_low_page,
  output logic              in_rom
);
  localparam logic [ADDR_W:0] PAGE_LIM = (ADDR_W+1)'(PAGE_BYTES);
  localparam logic [ADDR_W:0] ROM_END  = {1'b0, ROM_BASE} + ROM_SIZE;

  function automatic logic f_below(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W:0] lim);
    return {1'b0, a} < lim;
  endfunction

  function automatic logic f_inside(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input logic [ADDR_W:0] end_x);
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < end_x);
  endfunction

  assign in_low_page = f_below(addr, PAGE_LIM);

  generate
    if (ROM_SIZE == '0) begin : g_no_rom
      assign in_rom = 1'b0;
    end else begin : g_rom
      assign in_rom = f_inside(addr, ROM_BASE, ROM_END);
    end
  endgenerate
endmodule

// File: rtl/lpt_resp_stage.sv
module lpt_resp_stage
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              fetch,
  input  logic              write,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              low_hit,
  input  logic              rom_hit,
  input  logic              trap_en,
  input  logic              ovl_en,
  input  logic [WORD_W-1:0] ovl_val,
  output logic              resp_valid,
  output logic [WORD_W-1:0] resp_data,
  output logic              resp_trap
);
  logic data_acc_w, trap_fire_w, ovl_fire_w;

  assign data_acc_w  = req && !fetch;
  assign trap_fire_w = data_acc_w && low_hit && trap_en;
  assign ovl_fire_w  = data_acc_w && !write && rom_hit && ovl_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_trap  <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= req;
      resp_trap  <= trap_fire_w;
      if (req) resp_data <= ovl_fire_w ? ovl_val : mem_rdata;
    end
  end

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> resp_valid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !resp_valid && !resp_trap);
  p_trap_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire_w |=> resp_trap);
  p_fetch_no_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fetch) |=> !resp_trap);
  p_trap_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !trap_en) |=> !resp_trap);
  p_overlay_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_fire_w |=> resp_data == $past(ovl_val));
  p_fetch_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fetch) |=> resp_data == $past(mem_rdata));
  p_write_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && write) |=> resp_data == $past(mem_rdata));
endmodule

// File: rtl/low_page_guard.sv
module low_page_guard
  import lpt_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       PAGE_BYTES = 4096,
  parameter logic [ADDR_W-1:0] ROM_BASE   = 32'h0001_0000,
  parameter logic [ADDR_W:0]   ROM_SIZE   = 33'h0_0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              resp_valid,
  output logic [WORD_W-1:0] resp_data,
  output logic              resp_trap
);
  logic              trap_en_w, ovl_en_w;
  logic [WORD_W-1:0] ovl_val_w;
  logic              low_hit_w, rom_hit_w;

  lpt_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .trap_en (trap_en_w),
    .ovl_en  (ovl_en_w),
    .ovl_val (ovl_val_w)
  );

  lpt_addr_decode #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .ROM_BASE   (ROM_BASE),
    .ROM_SIZE   (ROM_SIZE)
  ) u_dec (
    .addr        (bus_addr),
    .in_low_page (low_hit_w),
    .in_rom      (rom_hit_w)
  );

  lpt_resp_stage u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (bus_req),
    .fetch      (bus_fetch),
    .write      (bus_write),
    .mem_rdata  (mem_rdata),
    .low_hit    (low_hit_w),
    .rom_hit    (rom_hit_w),
    .trap_en    (trap_en_w),
    .ovl_en     (ovl_en_w),
    .ovl_val    (ovl_val_w),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .resp_trap  (resp_trap)
  );

  // R9: a low page data read inside the window gets both actions at once
  p_both_actions_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_fetch && !bus_write && low_hit_w && rom_hit_w &&
     trap_en_w && ovl_en_w) |=> resp_trap && (resp_data == $past(ovl_val_w)));
endmodule

// File: tb/low_page_guard_tb_top.sv
`timescale 1ns/1ps
module low_page_guard_tb_top;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, cfg_rdata2;
  logic        bus_req = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic        bus_fetch = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        resp_valid, resp_trap, resp_valid2, resp_trap2;
  logic [31:0] resp_data, resp_data2;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  low_page_guard #(.ADDR_W(AW), .PAGE_BYTES(4096),
                   .ROM_BASE(16'h2000), .ROM_SIZE(17'h01000)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_trap(resp_trap));

  // window overlapping the low page
  low_page_guard #(.ADDR_W(AW), .PAGE_BYTES(4096),
                   .ROM_BASE(16'h0000), .ROM_SIZE(17'h00800)) dut_ovl_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata2), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .mem_rdata(mem_rdata), .resp_valid(resp_valid2), .resp_data(resp_data2),
    .resp_trap(resp_trap2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] s, input logic [31:0] exp);
    cfg_sel = s;
    #0.5;
    chk(tag, cfg_rdata, exp);
  endtask

  function automatic logic [AW-1:0] edge_addr(input int j);
    case (j)
      0: return 16'h0FFF;  1: return 16'h1000;
      2: return 16'h1FFF;  3: return 16'h2000;
      4: return 16'h2FFF;  5: return 16'h3000;
      6: return 16'h07FF;  7: return 16'h0800;
      default: return 16'hFFFF;
    endcase
  endfunction

  // one access; expected values from the requirements
  task automatic access(input logic [AW-1:0] a, input logic f, input logic w,
                        input logic [2:0] c, input logic [31:0] val);
    logic [31:0] mem;
    logic te, aux, oe, e_trap, e_ovl1, e_ovl2;
    te = c[0]; aux = c[1]; oe = c[2];
    mem = {a, ~a} ^ {30'd0, w, f};
    bus_req = 1'b1; bus_addr = a; bus_fetch = f; bus_write = w; mem_rdata = mem;
    @(negedge clk);
    e_trap = !f && te && (int'(a) < 4096);
    e_ovl1 = !f && !w && oe && (int'(a) >= 'h2000) && (int'(a) < 'h3000);
    e_ovl2 = !f && !w && oe && (int'(a) < 'h800);
    chk("R3 valid", {31'd0, resp_valid}, 32'd1);
    chk(e_trap ? "R4 trap" : (aux ? "R6 trap" : "R5 trap"), {31'd0, resp_trap}, {31'd0, e_trap});
    chk(e_ovl1 ? "R7 data" : (aux ? "R6 data" : "R8 data"), resp_data, e_ovl1 ? val : mem);
    chk((e_trap && e_ovl2) ? "R9 trap" : "R4 trap2", {31'd0, resp_trap2}, {31'd0, e_trap});
    chk((e_trap && e_ovl2) ? "R9 data" : "R8 data2", resp_data2, e_ovl2 ? val : mem);
  endtask

  task automatic idle_check();
    bus_req = 1'b0;
    @(negedge clk);
    chk("R10 valid idle", {31'd0, resp_valid}, 32'd0);
    chk("R10 trap idle", {31'd0, resp_trap}, 32'd0);
    chk("R10 trap idle2", {31'd0, resp_trap2}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'd0, resp_valid}, 32'd0);
    chk("R1 trap", {31'd0, resp_trap}, 32'd0);
    rd("R1 trap ctl", 2'd0, 32'h0001_0000);
    rd("R1 ovl ctl", 2'd1, 32'h0);
    rd("R1 ovl val", 2'd2, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 trap ctl after", 2'd0, 32'h0001_0000);

    // R2: register storage and masking
    wr(2'd0, 32'hFFFF_FFFF); rd("R2 trap ctl ones", 2'd0, 32'h0001_0001);
    wr(2'd0, 32'h0000_0000); rd("R2 trap ctl zero", 2'd0, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF); rd("R2 ovl ctl", 2'd1, 32'h1);
    wr(2'd2, 32'hA5C3_0F96); rd("R2 ovl val", 2'd2, 32'hA5C3_0F96);
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R2 sel3", 2'd3, 32'h0);
    rd("R2 sel3 no effect a", 2'd0, 32'h0);
    rd("R2 sel3 no effect b", 2'd1, 32'h1);
    rd("R2 sel3 no effect c", 2'd2, 32'hA5C3_0F96);

    // sweep every control combination, access kind and address
    for (int c = 0; c < 8; c++) begin
      logic [31:0] val;
      val = 32'h5EED_0000 ^ (c * 32'h0101_0011);
      wr(2'd0, {15'd0, c[1], 15'd0, c[0]});
      wr(2'd1, {31'd0, c[2]});
      wr(2'd2, val);
      for (int k = 0; k < 4; k++) begin
        for (int i = 0; i < 520; i++) begin
          logic [AW-1:0] a;
          a = (i < 512) ? AW'(i * 128) : edge_addr(i - 512);
          access(a, k[0], k[1], 3'(c), val);
        end
        idle_check();
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule